// File: doc/BRIEF.md
# Core-Local Interrupt Event Controller

This block sits beside a processor core and gathers up to 32 level-sensitive request lines into one interrupt request for the core. Each line has a sticky pending bit. The bit is set while its source is high. It stays set after the source drops, until software acknowledges the line through a write-one-to-clear register. Pending bits are gated by per-line enables. Among the active lines, the one with the highest priority value is chosen. Its number is reported together with the request and serves directly as the trap cause code.

Software reaches the block through a simple word-wide register port. A write takes effect on the clock edge where `reg_we_i` is high. Read data is combinational from the current address. Writes to read-only or unmapped words are dropped. The register port has no back-pressure and accepts one access per cycle. The request and line-number outputs are plain registered status, not a stream.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset, all enables, pending bits and priorities are zero, `irq_req_o` is 0 and `irq_id_o` is 0.
- R2: The enable register is at byte offset 0x00, with bit j enabling line j. It reads back what was written. Non-word-aligned addresses and unmapped words read 0 and ignore writes.
- R3: A line whose source is high at a clock edge has its pending bit set at that edge. Pending reads at offset 0x04 (bit j = line j), and writes to 0x04 change nothing.
- R4: A pending bit stays set after its source goes low, until it is cleared.
- R5: Writing offset 0x08 clears each pending bit whose written bit is 1 and leaves bits written 0 unchanged. Offset 0x08 reads as 0.
- R6: If a line's source is high in the same cycle as a clear write to that line, its pending bit stays set.
- R7: `irq_req_o` is 1 only when at least one line is both pending and enabled. A pending line that is disabled stays pending and raises no request. When `irq_req_o` is 0, `irq_id_o` is 0.
- R8: `irq_id_o` gives the number of the active line with the highest priority value. On equal priority, the lower line number wins.
- R9: Priorities are 3-bit fields in words at 0x10, 0x14, 0x18 and 0x1C. Line j sits in word 0x10 + 4*(j/8) at bits 4*(j%8)+2 down to 4*(j%8). Bit 4*(j%8)+3 reads 0.
- R10: `irq_req_o` and `irq_id_o` are registered. They reflect the pending, enable and priority state one clock edge after that state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_LINES | Level request lines |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_id_o | output | ID_W | Number of the selected line (trap cause code) |

## Verification
A source that is high before edge k shows up in the pending read at offset 0x04 after edge k. The same holds for a register write landing at edge k, whose effect is readable right after that edge. The request and line number follow one edge later, at k+1. The bench model applies state changes at each rising edge and computes the registered outputs from the state before that edge. It compares request, line number and read data at the falling edge, when both the design and the model have settled. Directed sequences check these counts explicitly, for example a pending bit that is visible while the request is still low.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int unsigned DATA_W         = 32;
  localparam int unsigned EN_WORD        = 0;
  localparam int unsigned PEND_WORD      = 1;
  localparam int unsigned CLR_WORD       = 2;
  localparam int unsigned PRIO_WORD0     = 4;
  localparam int unsigned SLOT_W         = 4;
  localparam int unsigned LINES_PER_WORD = DATA_W / SLOT_W;
endpackage

// File: rtl/evt_irq_pend.sv
module evt_irq_pend #(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] src_i,
  input  logic [NUM_LINES-1:0] clr_i,
  output logic [NUM_LINES-1:0] pend_o
);
  for (genvar j = 0; j < NUM_LINES; j++) begin : g_bit
    logic hold_q;
    // set has precedence over a clear in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hold_q <= 1'b0;
      else         hold_q <= (hold_q & ~clr_i[j]) | src_i[j];
    end
    assign pend_o[j] = hold_q;
  end
endmodule

// File: rtl/evt_irq_regs.sv
module evt_irq_regs
  import evt_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned PRIO_W    = 3,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [DATA_W-1:0]                 wdata_i,
  input  logic [NUM_LINES-1:0]              pend_i,
  output logic [DATA_W-1:0]                 rdata_o,
  output logic [NUM_LINES-1:0]              en_o,
  output logic [NUM_LINES-1:0][PRIO_W-1:0]  prio_o,
  output logic [NUM_LINES-1:0]              clr_o
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic              aligned;
  logic [WORD_W-1:0] word;
  logic              wr;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign word    = addr_i[ADDR_W-1:2];
  assign wr      = we_i && aligned;

  logic [NUM_LINES-1:0] en_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  en_q <= '0;
    else if (wr && word == WORD_W'(EN_WORD))      en_q <= wdata_i[NUM_LINES-1:0];
  end
  assign en_o = en_q;

  assign clr_o = (wr && word == WORD_W'(CLR_WORD)) ? wdata_i[NUM_LINES-1:0] : '0;

  logic [NUM_LINES-1:0][PRIO_W-1:0] prio_q;
  for (genvar j = 0; j < NUM_LINES; j++) begin : g_prio
    localparam int unsigned WSEL = PRIO_WORD0 + j / LINES_PER_WORD;
    localparam int unsigned LSB  = (j % LINES_PER_WORD) * SLOT_W;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          prio_q[j] <= '0;
      else if (wr && word == WORD_W'(WSEL)) prio_q[j] <= wdata_i[LSB +: PRIO_W];
    end
  end
  assign prio_o = prio_q;

  always_comb begin
    rdata_o = '0;
    if (aligned) begin
      if (word == WORD_W'(EN_WORD)) begin
        rdata_o[NUM_LINES-1:0] = en_q;
      end else if (word == WORD_W'(PEND_WORD)) begin
        rdata_o[NUM_LINES-1:0] = pend_i;
      end else begin
        for (int j = 0; j < NUM_LINES; j++) begin
          if (word == WORD_W'(PRIO_WORD0 + j / LINES_PER_WORD))
            rdata_o[(j % LINES_PER_WORD) * SLOT_W +: PRIO_W] = prio_q[j];
        end
      end
    end
  end
endmodule

// File: rtl/evt_irq_arb.sv
module evt_irq_arb #(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned PRIO_W    = 3,
  localparam int unsigned ID_W     = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0]             act_i,
  input  logic [NUM_LINES-1:0][PRIO_W-1:0] prio_i,
  output logic                             found_o,
  output logic [ID_W-1:0]                  id_o
);
  logic [PRIO_W-1:0] best_p;
  always_comb begin
    found_o = 1'b0;
    best_p  = '0;
    id_o    = '0;
    // ascending scan with strict compare keeps the lower index on ties
    for (int j = 0; j < NUM_LINES; j++) begin
      if (act_i[j] && (!found_o || prio_i[j] > best_p)) begin
        found_o = 1'b1;
        best_p  = prio_i[j];
        id_o    = ID_W'(j);
      end
    end
  end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned PRIO_W    = 3,
  parameter int unsigned ADDR_W    = 8,
  localparam int unsigned ID_W     = $clog2(NUM_LINES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] src_i,
  input  logic                 reg_we_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  output logic                 irq_req_o,
  output logic [ID_W-1:0]      irq_id_o
);
  logic [NUM_LINES-1:0]             pend_q;
  logic [NUM_LINES-1:0]             en_q;
  logic [NUM_LINES-1:0]             clr_mask;
  logic [NUM_LINES-1:0][PRIO_W-1:0] prio_q;
  logic                             win_found;
  logic [ID_W-1:0]                  win_id;

  evt_irq_pend #(.NUM_LINES(NUM_LINES)) pend_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .clr_i(clr_mask), .pend_o(pend_q)
  );

  evt_irq_regs #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) regs_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .pend_i(pend_q), .rdata_o(reg_rdata_o),
    .en_o(en_q), .prio_o(prio_q), .clr_o(clr_mask)
  );

  evt_irq_arb #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)) arb_i (
    .act_i(pend_q & en_q), .prio_i(prio_q), .found_o(win_found), .id_o(win_id)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_req_o <= 1'b0;
      irq_id_o  <= '0;
    end else begin
      irq_req_o <= win_found;
      irq_id_o  <= win_found ? win_id : '0;
    end
  end
endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk #(
  parameter int unsigned NUM_LINES = 32,
  localparam int unsigned ID_W     = $clog2(NUM_LINES)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_LINES-1:0] src_i,
  input logic [NUM_LINES-1:0] pend,
  input logic [NUM_LINES-1:0] en,
  input logic [NUM_LINES-1:0] clr,
  input logic                 irq_req,
  input logic [ID_W-1:0]      irq_id
);
  logic                 past_ok;
  logic [NUM_LINES-1:0] act_d;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      past_ok <= 1'b0;
      act_d   <= '0;
    end else begin
      past_ok <= 1'b1;
      act_d   <= pend & en;
    end
  end

  // R3
  pend_set_chk: assert property (@(posedge clk_i) disable iff (!past_ok)
    (($past(src_i) & ~pend) == '0));

  // R4
  pend_sticky_chk: assert property (@(posedge clk_i) disable iff (!past_ok)
    (($past(pend) & ~$past(clr) & ~pend) == '0));

  // R6
  set_beats_clear_chk: assert property (@(posedge clk_i) disable iff (!past_ok)
    (($past(src_i & clr) & ~pend) == '0));

  // R7
  req_gate_chk: assert property (@(posedge clk_i) disable iff (!past_ok)
    irq_req |-> act_d[irq_id]);

  // R7
  idle_id_chk: assert property (@(posedge clk_i) disable iff (!past_ok)
    !irq_req |-> (irq_id == '0));

  // R10
  req_latency_chk: assert property (@(posedge clk_i) disable iff (!past_ok)
    irq_req == (|act_d));
endmodule

bind evt_irq_ctrl evt_irq_chk #(.NUM_LINES(NUM_LINES)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .pend(pend_q), .en(en_q),
  .clr(clr_mask), .irq_req(irq_req_o), .irq_id(irq_id_o)
);

// File: tb/evt_irq_ctrl_tb.sv
`timescale 1ns/1ps
module evt_irq_ctrl_tb_top;
  localparam int NL = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic [4:0]  id;

  int n_cmp = 0;
  int n_bad = 0;
  bit chk_on = 0;

  always #2 clk = ~clk;

  evt_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_req_o(irq), .irq_id_o(id)
  );

  // behavioural reference
  logic [31:0] m_en, m_pend;
  int          m_prio [NL];
  logic        e_irq;
  int          e_id;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = '0; m_pend = '0; e_irq = 0; e_id = 0;
      for (int j = 0; j < NL; j++) m_prio[j] = 0;
    end else begin
      int best, bp;
      best = -1; bp = -1;
      for (int j = NL - 1; j >= 0; j--)
        if (m_en[j] && m_pend[j] && m_prio[j] >= bp) begin best = j; bp = m_prio[j]; end
      e_irq = (best >= 0);
      e_id  = (best >= 0) ? best : 0;
      if (we && addr[1:0] == 2'b00) begin
        if (addr == 8'h00) m_en = wdata;
        if (addr == 8'h08) m_pend = m_pend & ~wdata;
        if (addr >= 8'h10 && addr <= 8'h1C)
          for (int s = 0; s < 8; s++) m_prio[(addr - 8'h10) * 2 + s] = (wdata >> (4 * s)) & 7;
      end
      m_pend = m_pend | src;
    end
  end

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    logic [31:0] v;
    v = '0;
    if (a == 8'h00) v = m_en;
    else if (a == 8'h04) v = m_pend;
    else if (a >= 8'h10 && a <= 8'h1C && a[1:0] == 2'b00)
      for (int s = 0; s < 8; s++) v[4*s +: 4] = 4'(m_prio[(a - 8'h10) * 2 + s]);
    return v;
  endfunction

  function automatic string rd_tag(logic [7:0] a);
    if (a == 8'h00) return "R2";
    if (a == 8'h04) return "R3";
    if (a == 8'h08) return "R5";
    if (a >= 8'h10 && a <= 8'h1C) return "R9";
    return "R2";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      check("R10", 32'(irq), 32'(e_irq));
      check("R8", 32'(id), 32'(e_id));
      check(rd_tag(addr), rdata, exp_rd(addr));
    end
  end

  task automatic cyc(logic [31:0] s, logic w, logic [7:0] a, logic [31:0] d);
    @(posedge clk); #1;
    src = s; we = w; addr = a; wdata = d;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog expired: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", 32'(irq), 0);
    check("R1", 32'(id), 0);
    check("R1", rdata, 0);
    cyc(0, 0, 8'h04, 0); @(negedge clk); check("R1", rdata, 0);
    cyc(0, 0, 8'h10, 0); @(negedge clk); check("R1", rdata, 0);
    chk_on = 1;

    // R2 enable line 5
    cyc(0, 1, 8'h00, 32'h20);
    cyc(0, 0, 8'h00, 0); @(negedge clk); check("R2", rdata, 32'h20);
    // R10 latency: source high before edge k
    cyc(32'h20, 0, 8'h04, 0);
    cyc(0, 0, 8'h04, 0); @(negedge clk);
    check("R3", rdata, 32'h20);
    check("R10", 32'(irq), 0);
    cyc(0, 0, 8'h04, 0); @(negedge clk);
    check("R10", 32'(irq), 1);
    check("R8", 32'(id), 5);
    // R4 sticky after source dropped
    repeat (3) cyc(0, 0, 8'h04, 0);
    @(negedge clk);
    check("R4", rdata, 32'h20);
    check("R4", 32'(irq), 1);
    // R3 write to pending ignored
    cyc(0, 1, 8'h04, 32'h0);
    cyc(0, 0, 8'h04, 0); @(negedge clk); check("R3", rdata, 32'h20);
    // R5 clear with extra zero bits
    cyc(0, 1, 8'h08, 32'h20);
    cyc(0, 0, 8'h08, 0); @(negedge clk);
    check("R5", rdata, 0);
    check("R10", 32'(irq), 1);
    cyc(0, 0, 8'h04, 0); @(negedge clk);
    check("R5", rdata, 0);
    check("R7", 32'(irq), 0);
    check("R7", 32'(id), 0);
    // R6 set beats clear
    cyc(32'h200, 1, 8'h08, 32'h200);
    cyc(0, 0, 8'h04, 0); @(negedge clk); check("R6", rdata, 32'h200);
    // R7 disabled line 9 raises nothing
    cyc(0, 0, 8'h04, 0); @(negedge clk); check("R7", 32'(irq), 0);
    cyc(0, 1, 8'h08, 32'h200);
    // R8/R9 priorities: line1=6, line2=6, line12=7
    cyc(0, 1, 8'h10, 32'h0000_0660);
    cyc(0, 1, 8'h14, 32'h0007_0000);
    cyc(0, 1, 8'h00, 32'hFFFF_FFFF);
    cyc(32'h1006, 0, 8'h14, 0);
    cyc(0, 0, 8'h14, 0); @(negedge clk); check("R9", rdata, 32'h0007_0000);
    cyc(0, 0, 8'h10, 0); @(negedge clk);
    check("R8", 32'(id), 12);
    check("R9", rdata, 32'h0000_0660);
    cyc(0, 1, 8'h08, 32'h1000);
    cyc(0, 0, 8'h00, 0);
    cyc(0, 0, 8'h00, 0); @(negedge clk);
    check("R8", 32'(id), 1);
    // R9 bit 3 of each slot reads 0
    cyc(0, 1, 8'h1C, 32'hFFFF_FFFF);
    cyc(0, 0, 8'h1C, 0); @(negedge clk); check("R9", rdata, 32'h7777_7777);
    // R2 unaligned/unmapped writes ignored
    cyc(0, 1, 8'h01, 32'h0);
    cyc(0, 1, 8'h0C, 32'h0);
    cyc(0, 0, 8'h00, 0); @(negedge clk); check("R2", rdata, 32'hFFFF_FFFF);

    // random phase, compared each cycle by the model
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a;
      int pick;
      pick = $urandom_range(0, 8);
      case (pick)
        0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h08; 3: a = 8'h0C;
        4: a = 8'h10; 5: a = 8'h14; 6: a = 8'h18; 7: a = 8'h1C;
        default: a = 8'h02;
      endcase
      cyc($urandom & $urandom & $urandom & $urandom, ($urandom_range(0, 3) == 0), a, $urandom);
    end
    cyc(0, 0, 8'h00, 0);
    @(negedge clk);
    finish_run();
  end
endmodule